// File: doc/BRIEF.md
# Cursor and Light-Pen Address Unit

This unit sits next to the refresh address counter of a CRT controller. It is clocked once per character. On every clock it compares the live 14-bit refresh address with a cursor address that the host has programmed. When the two match during active display in text mode, it emits a cursor pulse that lasts one character clock and goes to the video path.

The unit also watches an asynchronous light-pen strobe. It brings the strobe into the character-clock domain and detects rising edges. On each rising edge it freezes the live refresh address into a read-only pair of registers. The host can then read this pair to find where the beam was when the pen fired.

The host reaches all four registers through a byte-wide port with a register selector and separate write and read strobes. Each 14-bit address is split into a high register and a low register. The high register holds bits 13:8 in its low six bits.

Top module: `cursor_lpen_unit`

## Requirements
- R1: After reset, the cursor and light-pen registers are zero, `cursorOut` is 0 and `rdData` is 0.
- R2: Selector 14 writes and reads cursor address bits 13:8 in data bits 5:0, and data bits 7:6 read back as 0. Selector 15 writes and reads cursor address bits 7:0.
- R3: `cursorOut` is 1 in the clock after a cycle in which `refreshAddr` equals the cursor address while both `dispEn` and `textMode` are 1. Otherwise it is 0.
- R4: The cursor pulse lasts exactly one clock, even if a matching address is held for several cycles.
- R5: No cursor pulse is produced while `dispEn` is 0 (retrace).
- R6: No cursor pulse is produced while `textMode` is 0.
- R7: A rising edge on `lpenStrobe` passes through two synchroniser flops and an edge detector. The refresh address present before the third clock edge after the strobe rises is stored. Selector 16 reads bits 13:8 of that address in data bits 5:0, and selector 17 reads bits 7:0.
- R8: A strobe that stays high, or that falls, stores nothing.
- R9: Writes to selectors 16 and 17 leave the light-pen registers unchanged.
- R10: If a capture and a read of selector 16 or 17 happen in the same cycle, the capture still completes. That read returns the previous value, and the next read returns the new one.
- R11: `rdData` is registered. It updates one clock after a cycle with `regRd` high and holds its value otherwise. Selectors other than 14 to 17 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refreshAddr | input | 14 | Live refresh address |
| dispEn | input | 1 | High during active scan, low during retrace |
| textMode | input | 1 | High when the display is in text mode |
| lpenStrobe | input | 1 | Asynchronous light-pen strobe |
| regSel | input | 5 | Register selector |
| regWr | input | 1 | Write strobe |
| regRd | input | 1 | Read strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Registered read data |
| cursorOut | output | 1 | One-clock cursor pulse |

## Verification
A light-pen capture and a host read of the capture registers can fall in the same clock. To provoke this, the bench raises the strobe and then asserts a read of selector 17 exactly two clocks later, which is the cycle in which the edge detector fires. The bench judges the outcome in two steps: that read must return the address from the earlier capture, and an immediate second read must return the newly frozen address. This shows that the capture was not lost and that the read was not torn.

// File: rtl/cursor_lpen_pkg.sv
package cursor_lpen_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CUR_HI,
    SEL_CUR_LO,
    SEL_PEN_HI,
    SEL_PEN_LO
  } rdSel_e;

  typedef struct packed {
    logic   wrCurHi;
    logic   wrCurLo;
    logic   capPen;
    logic   rdEn;
    rdSel_e rdSel;
  } ctlStrb_t;

endpackage

// File: rtl/cursor_lpen_ctrl.sv
module cursor_lpen_ctrl
  import cursor_lpen_pkg::*;
#(
  parameter int SEL_W      = 5,
  parameter int CUR_HI_IDX = 14,
  parameter int CUR_LO_IDX = 15,
  parameter int PEN_HI_IDX = 16,
  parameter int PEN_LO_IDX = 17,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lpenStrobe,
  input  logic [SEL_W-1:0] regSel,
  input  logic             regWr,
  input  logic             regRd,
  output ctlStrb_t         strb
);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   penPrev;
  logic                   penSync;

  // Synchroniser chain: stage 0 samples the pin.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncChain <= '0;
      penPrev   <= 1'b0;
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], lpenStrobe};
      penPrev   <= syncChain[SYNC_STAGES-1];
    end
  end

  assign penSync = syncChain[SYNC_STAGES-1];

  always_comb begin
    strb         = '0;
    strb.capPen  = penSync & ~penPrev;
    strb.rdEn    = regRd;
    strb.rdSel   = SEL_NONE;
    if (regWr) begin
      strb.wrCurHi = (regSel == SEL_W'(CUR_HI_IDX));
      strb.wrCurLo = (regSel == SEL_W'(CUR_LO_IDX));
    end
    if      (regSel == SEL_W'(CUR_HI_IDX)) strb.rdSel = SEL_CUR_HI;
    else if (regSel == SEL_W'(CUR_LO_IDX)) strb.rdSel = SEL_CUR_LO;
    else if (regSel == SEL_W'(PEN_HI_IDX)) strb.rdSel = SEL_PEN_HI;
    else if (regSel == SEL_W'(PEN_LO_IDX)) strb.rdSel = SEL_PEN_LO;
  end

  // R7
  cap_after_sync_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capPen |-> $past(syncChain[SYNC_STAGES-2]));

  // R8
  cap_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capPen |=> !strb.capPen);

  // R2
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrCurHi, strb.wrCurLo}));

endmodule

// File: rtl/cursor_lpen_datapath.sv
module cursor_lpen_datapath
  import cursor_lpen_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrb_t          strb,
  input  logic [ADDR_W-1:0] refreshAddr,
  input  logic              dispEn,
  input  logic              textMode,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              cursorOut
);

  localparam int HI_W  = ADDR_W - DATA_W;
  localparam int PAD_W = DATA_W - HI_W;

  logic [HI_W-1:0]   curHi;
  logic [DATA_W-1:0] curLo;
  logic [ADDR_W-1:0] penAddr;
  logic [ADDR_W-1:0] curAddr;
  logic              curHit;
  logic              curHitQ;
  logic [DATA_W-1:0] rdNext;

  assign curAddr = {curHi, curLo};
  assign curHit  = textMode & dispEn & (refreshAddr == curAddr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curHi <= '0;
      curLo <= '0;
    end else begin
      if (strb.wrCurHi) curHi <= wrData[HI_W-1:0];
      if (strb.wrCurLo) curLo <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            penAddr <= '0;
    else if (strb.capPen) penAddr <= refreshAddr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curHitQ   <= 1'b0;
      cursorOut <= 1'b0;
    end else begin
      curHitQ   <= curHit;
      cursorOut <= curHit & ~curHitQ;
    end
  end

  always_comb begin
    case (strb.rdSel)
      SEL_CUR_HI: rdNext = {{PAD_W{1'b0}}, curHi};
      SEL_CUR_LO: rdNext = curLo;
      SEL_PEN_HI: rdNext = {{PAD_W{1'b0}}, penAddr[ADDR_W-1:DATA_W]};
      SEL_PEN_LO: rdNext = penAddr[DATA_W-1:0];
      default:    rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rdData <= '0;
    else if (strb.rdEn) rdData <= rdNext;
  end

  // R3
  cursor_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    cursorOut |-> $past(dispEn && textMode));

  // R4
  cursor_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    cursorOut |=> !cursorOut);

  // R7
  pen_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capPen |=> penAddr == $past(refreshAddr));

  // R9
  pen_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capPen |=> $stable(penAddr));

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdEn |=> $stable(rdData));

endmodule

// File: rtl/cursor_lpen_unit.sv
module cursor_lpen_unit
  import cursor_lpen_pkg::*;
#(
  parameter int ADDR_W     = 14,
  parameter int DATA_W     = 8,
  parameter int SEL_W      = 5,
  parameter int CUR_HI_IDX = 14,
  parameter int CUR_LO_IDX = 15,
  parameter int PEN_HI_IDX = 16,
  parameter int PEN_LO_IDX = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] refreshAddr,
  input  logic              dispEn,
  input  logic              textMode,
  input  logic              lpenStrobe,
  input  logic [SEL_W-1:0]  regSel,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              cursorOut
);

  ctlStrb_t strb;

  cursor_lpen_ctrl #(
    .SEL_W(SEL_W), .CUR_HI_IDX(CUR_HI_IDX), .CUR_LO_IDX(CUR_LO_IDX),
    .PEN_HI_IDX(PEN_HI_IDX), .PEN_LO_IDX(PEN_LO_IDX), .SYNC_STAGES(2)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .lpenStrobe(lpenStrobe),
    .regSel(regSel), .regWr(regWr), .regRd(regRd), .strb(strb)
  );

  cursor_lpen_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .refreshAddr(refreshAddr),
    .dispEn(dispEn), .textMode(textMode), .wrData(wrData),
    .rdData(rdData), .cursorOut(cursorOut)
  );

endmodule

// File: tb/tb_cursor_lpen_unit.sv
module tb_cursor_lpen_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [13:0] refreshAddr = '0;
  logic        dispEn = 1'b0;
  logic        textMode = 1'b0;
  logic        lpenStrobe = 1'b0;
  logic [4:0]  regSel = '0;
  logic        regWr = 1'b0;
  logic        regRd = 1'b0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic        cursorOut;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  cursor_lpen_unit dut (
    .clk(clk), .rstN(rstN), .refreshAddr(refreshAddr), .dispEn(dispEn),
    .textMode(textMode), .lpenStrobe(lpenStrobe), .regSel(regSel),
    .regWr(regWr), .regRd(regRd), .wrData(wrData), .rdData(rdData),
    .cursorOut(cursorOut)
  );

  // fields: cursor addr, refresh addr, dispEn, textMode, expected pulse
  localparam logic [30:0] VEC [0:7] = '{
    {14'h0123, 14'h0123, 1'b1, 1'b1, 1'b1},
    {14'h3FFF, 14'h3FFF, 1'b1, 1'b1, 1'b1},
    {14'h0000, 14'h0000, 1'b1, 1'b1, 1'b1},
    {14'h0123, 14'h0124, 1'b1, 1'b1, 1'b0},
    {14'h2000, 14'h0000, 1'b1, 1'b1, 1'b0},
    {14'h0ABC, 14'h0ABC, 1'b0, 1'b1, 1'b0},
    {14'h0ABC, 14'h0ABC, 1'b1, 1'b0, 1'b0},
    {14'h1555, 14'h1555, 1'b1, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [4:0] sel, input logic [7:0] d);
    regSel = sel; wrData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdReg(input logic [4:0] sel, output logic [7:0] d);
    regSel = sel; regRd = 1'b1;
    @(negedge clk);
    regRd = 1'b0;
    d = rdData;
  endtask

  task automatic setCursor(input logic [13:0] a);
    wrReg(5'd14, {2'b00, a[13:8]});
    wrReg(5'd15, a[7:0]);
  endtask

  initial begin
    #(200000 * 8);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [13:0] ca;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk("R1 cursorOut", 16'(cursorOut), 16'h0);
    chk("R1 rdData", 16'(rdData), 16'h0);
    for (int s = 14; s < 18; s++) begin
      rdReg(5'(s), d);
      chk("R1 reg", 16'(d), 16'h0);
    end

    // R2 register access
    wrReg(5'd14, 8'hFF);
    rdReg(5'd14, d); chk("R2 hi byte", 16'(d), 16'h3F);
    wrReg(5'd15, 8'h5A);
    rdReg(5'd15, d); chk("R2 lo byte", 16'(d), 16'h5A);

    // R3 R5 R6 table
    for (int i = 0; i < 8; i++) begin
      ca = VEC[i][30:17];
      dispEn = 1'b1; textMode = 1'b1;
      refreshAddr = ca ^ 14'h0001;
      setCursor(ca);
      @(negedge clk);
      refreshAddr = VEC[i][16:3];
      dispEn = VEC[i][2];
      textMode = VEC[i][1];
      @(negedge clk);
      chk("R3/R5/R6 pulse", 16'(cursorOut), 16'(VEC[i][0]));
      refreshAddr = ca ^ 14'h0001;
      dispEn = 1'b1; textMode = 1'b1;
      @(negedge clk);
      chk("R3 pulse ends", 16'(cursorOut), 16'h0);
    end

    // R4 held match gives one pulse
    refreshAddr = 14'h0777;
    setCursor(14'h0778);
    @(negedge clk);
    refreshAddr = 14'h0778;
    @(negedge clk); chk("R4 first", 16'(cursorOut), 16'h1);
    @(negedge clk); chk("R4 second", 16'(cursorOut), 16'h0);
    @(negedge clk); chk("R4 third", 16'(cursorOut), 16'h0);
    refreshAddr = 14'h0000;

    // R7 capture
    refreshAddr = 14'h2A5C;
    lpenStrobe = 1'b1;
    repeat (3) @(negedge clk);
    rdReg(5'd16, d); chk("R7 pen hi", 16'(d), 16'h2A);
    rdReg(5'd17, d); chk("R7 pen lo", 16'(d), 16'h5C);

    // R8 held high, then falling
    refreshAddr = 14'h1111;
    repeat (4) @(negedge clk);
    rdReg(5'd17, d); chk("R8 held high", 16'(d), 16'h5C);
    lpenStrobe = 1'b0;
    repeat (4) @(negedge clk);
    rdReg(5'd17, d); chk("R8 falling", 16'(d), 16'h5C);

    // R9 writes ignored
    wrReg(5'd16, 8'hFF);
    wrReg(5'd17, 8'h00);
    rdReg(5'd16, d); chk("R9 pen hi", 16'(d), 16'h2A);
    rdReg(5'd17, d); chk("R9 pen lo", 16'(d), 16'h5C);

    // R10 capture and read same cycle
    refreshAddr = 14'h0F0F;
    lpenStrobe = 1'b1;
    repeat (2) @(negedge clk);
    rdReg(5'd17, d); chk("R10 same-cycle read", 16'(d), 16'h5C);
    rdReg(5'd17, d); chk("R10 next read", 16'(d), 16'h0F);
    rdReg(5'd16, d); chk("R10 next hi", 16'(d), 16'h0F);
    lpenStrobe = 1'b0;

    // R11 unused selectors and hold
    rdReg(5'd3, d);  chk("R11 sel 3", 16'(d), 16'h0);
    rdReg(5'd15, d); chk("R11 sel 15", 16'(d), 16'h78);
    regSel = 5'd14;
    repeat (2) @(negedge clk);
    chk("R11 hold", 16'(rdData), 16'h78);
    rdReg(5'd13, d); chk("R11 sel 13", 16'(d), 16'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule